// File: doc/BRIEF.md
# Synchronous Single-Port RAM with Write-Mode Output Policy

This block is a single-port memory with one clock. Reads and writes take effect on the rising edge. Every access goes through an enable. The read result always comes out of an output register. Each stored word has a data field and a side field of check bits. Both fields are written and returned together.

An elaboration-time parameter sets what the output register shows on a cycle that writes:
- the word as it was before the write,
- the word being written, or
- its own previous value.

A synchronous output-clear input loads a parameter constant into the output register. It does not touch the array. At start-up the array contents and the output register come from parameters, so the block can act as an initialised table.

Depth, data width and side-field width are parameters. The initial array image is one wide vector made of 64 chunks of 256 bits each.

Top module: `sram_wm`

## Requirements
- R1: On a rising edge with `en`=1, `wr_en`=0 and `out_sync_rst`=0, {`rpar`,`rdata`} takes the word stored at `addr`. The outputs change only at rising edges.
- R2: On an edge with `en`=0 the array is not written and {`rpar`,`rdata`} keeps its value, whatever `wr_en`, `addr`, `wdata` and `wpar` carry.
- R3: With `MODE`=WM_READ_FIRST (encoding 0, the default), a write edge stores {`wpar`,`wdata`} at `addr`. The output shows the word that location held before that edge.
- R4: With `MODE`=WM_WRITE_FIRST (encoding 1), a write edge stores the new word and the output shows that same new word.
- R5: With `MODE`=WM_NO_CHANGE (encoding 2), a write edge stores the new word and the output register keeps its previous value.
- R6: On an edge with `en`=1 and `out_sync_rst`=1 the output takes `SR_VAL` in every mode. If `wr_en`=1 on that edge, the write to the array still happens.
- R7: `out_sync_rst` has no effect on an edge where `en`=0.
- R8: Before the first enabled edge the output equals `OUT_INIT` (bits [DATA_W-1:0] on `rdata`, the rest on `rpar`).
- R9: The initial data of word a is `INIT_DATA[a*DATA_W +: DATA_W]`. Chunk k is bits [256k+255:256k], so chunk 0 holds the lowest addresses with the lowest word at the right. The initial side field of word a is `INIT_PAR[a*PAR_W +: PAR_W]`.
- R10: The side field follows the same write, read, hold and clear rules as the data field, lane for lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all activity |
| en | input | 1 | Access enable; when low, nothing changes |
| wr_en | input | 1 | Write request, qualified by `en` |
| out_sync_rst | input | 1 | Synchronous load of `SR_VAL` into the output register, qualified by `en` |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data field |
| wpar | input | PAR_W | Write side (check-bit) field |
| rdata | output | DATA_W | Registered data field |
| rpar | output | PAR_W | Registered side field |

## Verification
The hardest case to reach is a write on the same edge as an output clear. The clear hides that write from the output, so it only shows up on a later read of that address. Similarly, a write attempted with the enable low shows up only as an unchanged word on a later read. The stimulus creates both cases directly, with a write at a known address followed by a read of the same address. Random traffic is confined half of the time to a 16-word window, so that write-then-read and write-after-write collisions on one address happen often in all three mode instances. Those instances run side by side on identical inputs.

// File: rtl/sram_wm_pkg.sv
package sram_wm_pkg;

    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    // Source the output register loads from on an edge
    typedef enum logic [1:0] {
        OS_HOLD,
        OS_CLEAR,
        OS_OLD,
        OS_NEW
    } out_sel_e;

    localparam int CHUNK_BITS     = 256;
    localparam int CHUNK_COUNT    = 64;
    localparam int INIT_BITS      = CHUNK_BITS * CHUNK_COUNT;
    localparam int PAR_CHUNKS     = 8;
    localparam int PAR_INIT_BITS  = CHUNK_BITS * PAR_CHUNKS;

    typedef struct packed {
        logic en;
        logic we;
        logic clr;
    } access_t;

    function automatic out_sel_e pick_out(wmode_e m, access_t acc);
        if (!acc.en)  return OS_HOLD;
        if (acc.clr)  return OS_CLEAR;
        if (!acc.we)  return OS_OLD;
        case (m)
            WM_WRITE_FIRST: return OS_NEW;
            WM_NO_CHANGE:   return OS_HOLD;
            default:        return OS_OLD;
        endcase
    endfunction

endpackage

// File: rtl/sram_wm_array.sv
module sram_wm_array
    import sram_wm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int PAR_W  = 4,
    parameter logic [INIT_BITS-1:0]     INIT_DATA = '0,
    parameter logic [PAR_INIT_BITS-1:0] INIT_PAR  = '0
) (
    input  logic                      clk,
    input  logic                      wr_fire,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W+PAR_W-1:0]   wr_word,
    output logic [DATA_W+PAR_W-1:0]   cur_word
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = DATA_W + PAR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [DATA_W-1:0] d;
            logic [PAR_W-1:0]  p;
            d = '0;
            p = '0;
            if ((i + 1) * DATA_W <= INIT_BITS)
                d = INIT_DATA[i*DATA_W +: DATA_W];
            if ((i + 1) * PAR_W <= PAR_INIT_BITS)
                p = INIT_PAR[i*PAR_W +: PAR_W];
            mem[i] = {p, d};
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire)
            mem[addr] <= wr_word;
    end

    // Contents before the current edge; sampled by the output stage
    assign cur_word = mem[addr];

endmodule

// File: rtl/sram_wm_outreg.sv
module sram_wm_outreg
    import sram_wm_pkg::*;
#(
    parameter int     WORD_W = 36,
    parameter wmode_e MODE   = WM_READ_FIRST,
    parameter logic [WORD_W-1:0] OUT_INIT = '0,
    parameter logic [WORD_W-1:0] SR_VAL   = '0
) (
    input  logic              clk,
    input  access_t           acc,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] q_r = OUT_INIT;
    out_sel_e          sel;

    assign sel = pick_out(MODE, acc);

    always_ff @(posedge clk) begin
        case (sel)
            OS_CLEAR: q_r <= SR_VAL;
            OS_OLD:   q_r <= old_word;
            OS_NEW:   q_r <= new_word;
            default:  q_r <= q_r;
        endcase
    end

    assign q = q_r;

endmodule

// File: rtl/sram_wm.sv
module sram_wm
    import sram_wm_pkg::*;
#(
    parameter int     ADDR_W = 9,
    parameter int     DATA_W = 32,
    parameter int     PAR_W  = 4,
    parameter wmode_e MODE   = WM_READ_FIRST,
    parameter logic [DATA_W+PAR_W-1:0] OUT_INIT  = '0,
    parameter logic [DATA_W+PAR_W-1:0] SR_VAL    = '0,
    parameter logic [INIT_BITS-1:0]     INIT_DATA = '0,
    parameter logic [PAR_INIT_BITS-1:0] INIT_PAR  = '0
) (
    input  logic              clk,
    input  logic              en,
    input  logic              wr_en,
    input  logic              out_sync_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAR_W-1:0]  wpar,
    output logic [DATA_W-1:0] rdata,
    output logic [PAR_W-1:0]  rpar
);
    localparam int WORD_W = DATA_W + PAR_W;

    access_t           acc;
    logic [WORD_W-1:0] new_word;
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] q;

    assign acc      = '{en: en, we: wr_en, clr: out_sync_rst};
    assign new_word = {wpar, wdata};

    sram_wm_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W),
        .INIT_DATA(INIT_DATA), .INIT_PAR(INIT_PAR)
    ) array_i (
        .clk(clk), .wr_fire(en && wr_en), .addr(addr),
        .wr_word(new_word), .cur_word(old_word)
    );

    sram_wm_outreg #(
        .WORD_W(WORD_W), .MODE(MODE), .OUT_INIT(OUT_INIT), .SR_VAL(SR_VAL)
    ) outreg_i (
        .clk(clk), .acc(acc), .old_word(old_word),
        .new_word(new_word), .q(q)
    );

    assign rdata = q[DATA_W-1:0];
    assign rpar  = q[WORD_W-1:DATA_W];

endmodule

// File: rtl/sram_wm_chk.sv
module sram_wm_chk
    import sram_wm_pkg::*;
#(
    parameter int     ADDR_W = 9,
    parameter int     DATA_W = 32,
    parameter int     PAR_W  = 4,
    parameter wmode_e MODE   = WM_READ_FIRST,
    parameter logic [DATA_W+PAR_W-1:0] SR_VAL = '0
) (
    input logic              clk,
    input logic              en,
    input logic              wr_en,
    input logic              out_sync_rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [PAR_W-1:0]  wpar,
    input logic [DATA_W-1:0] rdata,
    input logic [PAR_W-1:0]  rpar
);
    logic [DATA_W+PAR_W-1:0] dout;
    assign dout = {rpar, rdata};

    // R2, R7: idle edge leaves the output alone
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (out_sync_rst)
        !en |=> $stable(dout));

    a_r7_clear_needs_en: assert property (@(posedge clk) disable iff (en)
        (!en && out_sync_rst) |=> $stable(dout));

    // R6: enabled clear loads the constant
    a_r6_clear_load: assert property (@(posedge clk) disable iff (!en)
        out_sync_rst |=> (dout == SR_VAL));

    // R1, R6: a stored word (written even under clear) reads back next edge
    a_r1_write_readback: assert property (@(posedge clk) disable iff (1'b0)
        (en && wr_en) ##1 (en && !wr_en && !out_sync_rst && addr == $past(addr))
        |=> (dout == $past({wpar, wdata}, 2)));

    generate
        if (MODE == WM_WRITE_FIRST) begin : g_wf
            a_r4_shows_new: assert property (@(posedge clk) disable iff (out_sync_rst)
                (en && wr_en) |=> (dout == $past({wpar, wdata})));
        end else if (MODE == WM_NO_CHANGE) begin : g_nc
            a_r5_write_holds: assert property (@(posedge clk) disable iff (out_sync_rst)
                (en && wr_en) |=> $stable(dout));
        end else begin : g_rf
            // R3: write after a write to the same address shows the first one
            a_r3_shows_old: assert property (@(posedge clk) disable iff (out_sync_rst)
                (en && wr_en && !out_sync_rst) ##1 (en && wr_en && addr == $past(addr))
                |=> (dout == $past({wpar, wdata}, 2)));
        end
    endgenerate

endmodule

bind sram_wm sram_wm_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W),
    .MODE(MODE), .SR_VAL(SR_VAL)
) chk_i (
    .clk(clk), .en(en), .wr_en(wr_en), .out_sync_rst(out_sync_rst),
    .addr(addr), .wdata(wdata), .wpar(wpar), .rdata(rdata), .rpar(rpar)
);

// File: tb/sram_wm_tb_top.sv
`timescale 1ns/1ps
module sram_wm_tb_top;
    import sram_wm_pkg::*;

    localparam int AW = 9;
    localparam int DW = 32;
    localparam int PW = 4;
    localparam int WW = DW + PW;
    localparam int DEPTH = 1 << AW;
    localparam logic [WW-1:0] SRV   = 36'hC_DEAD_BEEF;
    localparam logic [WW-1:0] OINIT = 36'h3_1234_5678;

    function automatic logic [DW-1:0] dat_f(int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic [PW-1:0] par_f(int i);
        return 4'(i) ^ 4'h5;
    endfunction
    function automatic logic [INIT_BITS-1:0] mk_data();
        logic [INIT_BITS-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) v[i*DW +: DW] = dat_f(i);
        return v;
    endfunction
    function automatic logic [PAR_INIT_BITS-1:0] mk_par();
        logic [PAR_INIT_BITS-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) v[i*PW +: PW] = par_f(i);
        return v;
    endfunction
    localparam logic [INIT_BITS-1:0]     IDATA = mk_data();
    localparam logic [PAR_INIT_BITS-1:0] IPAR  = mk_par();

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic en = 0, we = 0, sr = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wd = '0;
    logic [PW-1:0] wp = '0;
    logic [DW-1:0] rd [3];
    logic [PW-1:0] rp [3];

    sram_wm #(.ADDR_W(AW), .DATA_W(DW), .PAR_W(PW), .MODE(WM_READ_FIRST),
        .OUT_INIT(OINIT), .SR_VAL(SRV), .INIT_DATA(IDATA), .INIT_PAR(IPAR)) dut_i (
        .clk(clk), .en(en), .wr_en(we), .out_sync_rst(sr), .addr(addr),
        .wdata(wd), .wpar(wp), .rdata(rd[0]), .rpar(rp[0]));
    sram_wm #(.ADDR_W(AW), .DATA_W(DW), .PAR_W(PW), .MODE(WM_WRITE_FIRST),
        .OUT_INIT(OINIT), .SR_VAL(SRV), .INIT_DATA(IDATA), .INIT_PAR(IPAR)) dut_wf_i (
        .clk(clk), .en(en), .wr_en(we), .out_sync_rst(sr), .addr(addr),
        .wdata(wd), .wpar(wp), .rdata(rd[1]), .rpar(rp[1]));
    sram_wm #(.ADDR_W(AW), .DATA_W(DW), .PAR_W(PW), .MODE(WM_NO_CHANGE),
        .OUT_INIT(OINIT), .SR_VAL(SRV), .INIT_DATA(IDATA), .INIT_PAR(IPAR)) dut_nc_i (
        .clk(clk), .en(en), .wr_en(we), .out_sync_rst(sr), .addr(addr),
        .wdata(wd), .wpar(wp), .rdata(rd[2]), .rpar(rp[2]));

    logic [WW-1:0] mem_m [DEPTH];
    logic [WW-1:0] exp_o [3];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic cmp(int k, string req, logic [WW-1:0] e);
        n_vec++;
        if (rd[k] !== e[DW-1:0]) begin
            n_bad++;
            $display("FAIL %s dut%0d rdata actual=%h expected=%h", req, k, rd[k], e[DW-1:0]);
        end
        if (rp[k] !== e[WW-1:DW]) begin
            n_bad++;
            $display("FAIL R10 dut%0d rpar actual=%h expected=%h", k, rp[k], e[WW-1:DW]);
        end
    endtask

    // Apply one edge, update the model, compare all three instances
    task automatic step(bit e, bit w, bit s, logic [AW-1:0] a,
                        logic [DW-1:0] d, logic [PW-1:0] p, string tag);
        logic [WW-1:0] oldw;
        string req;
        en = e; we = w; sr = s; addr = a; wd = d; wp = p;
        @(posedge clk);
        #1;
        oldw = mem_m[a];
        for (int k = 0; k < 3; k++) begin
            req = tag;
            if (req == "") begin
                if (!e)        req = s ? "R7" : "R2";
                else if (s)    req = "R6";
                else if (!w)   req = "R1";
                else           req = (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
            end
            if (e) begin
                if (s)            exp_o[k] = SRV;
                else if (!w)      exp_o[k] = oldw;
                else if (k == 0)  exp_o[k] = oldw;
                else if (k == 1)  exp_o[k] = {p, d};
            end
            cmp(k, req, exp_o[k]);
        end
        if (e && w) mem_m[a] = {p, d};
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = {par_f(i), dat_f(i)};
        for (int k = 0; k < 3; k++) exp_o[k] = OINIT;
        #1;
        for (int k = 0; k < 3; k++) cmp(k, "R8", OINIT);           // R8 start-up value
        step(0, 0, 0, 9'd3, '0, '0, "R8");                          // idle edge keeps R8
        step(1, 0, 0, 9'd0,   '0, '0, "R9");                        // R9 lowest word
        step(1, 0, 0, 9'd7,   '0, '0, "R9");                        // R9 inside chunk 0
        step(1, 0, 0, 9'd8,   '0, '0, "R9");                        // R9 chunk 1 start
        step(1, 0, 0, 9'd511, '0, '0, "R9");                        // R9 top word
        step(0, 1, 0, 9'd5, 32'hFFFF_0000, 4'hA, "R2");             // disabled write
        step(1, 0, 0, 9'd5, '0, '0, "R2");                          // R2 word 5 unchanged
        step(1, 1, 1, 9'd6, 32'h1357_9BDF, 4'h3, "R6");             // clear + write
        step(1, 0, 0, 9'd6, '0, '0, "R6");                          // R6 write landed
        step(1, 0, 0, 9'd1, '0, '0, "");
        step(0, 0, 1, 9'd1, '0, '0, "R7");                          // R7 clear ignored
        step(1, 1, 0, 9'd9, 32'hAAAA_5555, 4'hF, "");               // R3/R4/R5
        step(1, 1, 0, 9'd9, 32'h0F0F_F0F0, 4'h0, "");               // second write same addr
        step(1, 0, 0, 9'd9, '0, '0, "R1");
        process::self().srandom(32'd1234);
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] a;
            a = ($urandom_range(0, 1) == 0) ? AW'($urandom_range(0, 15)) : AW'($urandom);
            step($urandom_range(0, 9) < 8, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 9) == 0, a, $urandom, 4'($urandom), "");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule